// File: doc/BRIEF.md
# DMA Channel Run-Control Sequencer

This block decides whether one DMA channel is stopped, running or held. It watches three control bits that software writes (enable, continue, and a resume-from-start selector), a fetch-error flag and the completion reports that the data engine gives at the end of each descriptor. From these it keeps the channel state, reports a 2-bit status code, and issues single-cycle commands. It tells the pointer unit to reload the descriptor pointers from the programmed start addresses or to step to the next descriptor. It asks for the next descriptor to be fetched. It also raises the transfer-done and paused status events.

A completion report carries the descriptor's 2-bit command field and a flag that says whether the descriptors came from registers (register-pointer mode) or from memory. A halt command holds the channel. Software then resumes it by writing enable with continue set. The resume-from-start selector chooses between restarting at the start addresses and stepping to the following descriptor. The continue bit is consumed by the resume and clears itself.

All decisions take effect at one clock edge. The state, status and enable/continue bits change at that edge, and the command pulses are high for exactly the following cycle.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset the status reads 0 (stopped), the enable and continue bits read 0, and no command pulse is high. Status codes are 0 stopped, 1 running, 2 held.
- R2: A fetch error reported while running sets a sticky error flag and stops the channel. While the flag is set the status reads 3, and a completion reported in the same cycle as the error is ignored. A fetch error while stopped or held has no effect.
- R3: A write with enable=1 while stopped pulses pointer-reload and fetch-request, and the channel becomes running.
- R4: A write with enable=1 and continue=1 while held resumes the channel. If resume-from-start=1 it pulses pointer-reload, otherwise pointer-advance, and in both cases fetch-request. The continue bit reads 0 afterwards and the status becomes running.
- R5: A write with enable=0 and continue=1 while held stops the channel. With continue=0 the channel stays held.
- R6: Any write with enable=1 clears the error flag.
- R7: Every completion accepted while running pulses transfer-done.
- R8: A completion in register-pointer mode (flag=1), or one with command field 2, clears the enable bit and stops the channel.
- R9: In memory mode a completion with command field 1 holds the channel and pulses paused. Command fields 0 and 3 pulse pointer-advance and fetch-request, and the channel keeps running.
- R10: A write that matches no rule above changes neither the state nor the pulses. Examples are enable=1 while running, or enable=1 with continue=0 while held. The enable and continue bits still take the written values.
- R11: When a completion and a write arrive in the same cycle, the completion is applied first and the write is judged against the state it leaves.
- R12: Pointer-reload and pointer-advance are never high together, and fetch-request is only high together with one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Written enable value |
| ctl_cont | input | 1 | Written continue value |
| ctl_cont_start | input | 1 | Written resume-from-start selector |
| fetch_err | input | 1 | Descriptor fetch error |
| dsc_done | input | 1 | Descriptor completed |
| dsc_cmd | input | 2 | Command field of the completed descriptor (1 halt, 2 stop) |
| dsc_reg_mode | input | 1 | Completed descriptor was register-pointer mode |
| chan_status | output | 2 | Status code (0/1/2, 3 on error) |
| en_bit | output | 1 | Current enable bit |
| cont_bit | output | 1 | Current continue bit |
| ptr_reload | output | 1 | Reload pointers from start addresses |
| ptr_advance | output | 1 | Step source pointer to next descriptor |
| fetch_req | output | 1 | Request the next descriptor fetch |
| done_pulse | output | 1 | Transfer-done event |
| pause_pulse | output | 1 | Paused event |

## Verification
A descriptor completion and a software control write can land on the same edge. A halt completion with a resume write in the same cycle must hold and then resume at once. A stop completion with an enable write must stop and then restart with a reload. The bench provokes this by placing channels in each reachable state and applying every combination of write, completion, command, mode and error inputs in one cycle. It judges the results against an arithmetic model that applies the completion before the write. A fetch error that coincides with an enable write is also covered: the error is latched and then cleared in the same step.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;

  localparam int CMD_W   = 2;
  localparam int STAT_W  = 2;
  localparam int PULSE_N = 5;

  localparam int PI_RELOAD = 0;
  localparam int PI_ADV    = 1;
  localparam int PI_FETCH  = 2;
  localparam int PI_DONE   = 3;
  localparam int PI_PAUSE  = 4;

  typedef logic [CMD_W-1:0] cmd_t;

  typedef enum logic [STAT_W-1:0] {
    CH_OFF  = 2'd0,
    CH_RUN  = 2'd1,
    CH_HOLD = 2'd2
  } ch_state_e;

  localparam cmd_t CMD_HALT = cmd_t'(1);
  localparam cmd_t CMD_STOP = cmd_t'(2);
  localparam logic [STAT_W-1:0] STAT_ERR = '1;

  function automatic logic [STAT_W-1:0] status_code(ch_state_e st, logic err);
    return err ? STAT_ERR : STAT_W'(st);
  endfunction

  function automatic logic ends_channel(logic reg_mode, cmd_t cmd);
    return reg_mode || (cmd == CMD_STOP);
  endfunction

  function automatic logic holds_channel(logic reg_mode, cmd_t cmd);
    return !reg_mode && (cmd == CMD_HALT);
  endfunction

endpackage

// File: rtl/dma_rc_completion.sv
module dma_rc_completion
  import dma_rc_pkg::*;
(
  input  ch_state_e st_i,
  input  logic      err_i,
  input  logic      en_i,
  input  logic      fetch_err_i,
  input  logic      dsc_done_i,
  input  cmd_t      dsc_cmd_i,
  input  logic      reg_mode_i,
  output ch_state_e st_o,
  output logic      err_o,
  output logic      en_o,
  output logic      done_o,
  output logic      pause_o,
  output logic      adv_o,
  output logic      fetch_o
);

  logic running;
  assign running = (st_i == CH_RUN);

  always_comb begin
    st_o    = st_i;
    err_o   = err_i;
    en_o    = en_i;
    done_o  = 1'b0;
    pause_o = 1'b0;
    adv_o   = 1'b0;
    fetch_o = 1'b0;
    if (running && fetch_err_i) begin
      err_o = 1'b1;
      st_o  = CH_OFF;
    end else if (running && dsc_done_i) begin
      done_o = 1'b1;
      if (ends_channel(reg_mode_i, dsc_cmd_i)) begin
        en_o = 1'b0;
        st_o = CH_OFF;
      end else if (holds_channel(reg_mode_i, dsc_cmd_i)) begin
        st_o    = CH_HOLD;
        pause_o = 1'b1;
      end else begin
        adv_o   = 1'b1;
        fetch_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_rc_write_eval.sv
module dma_rc_write_eval
  import dma_rc_pkg::*;
(
  input  ch_state_e st_i,
  input  logic      err_i,
  input  logic      en_i,
  input  logic      cont_i,
  input  logic      wr_i,
  input  logic      wen_i,
  input  logic      wcont_i,
  input  logic      wstart_i,
  output ch_state_e st_o,
  output logic      err_o,
  output logic      en_o,
  output logic      cont_o,
  output logic      reload_o,
  output logic      adv_o,
  output logic      fetch_o
);

  logic resume_ev, start_ev, leave_ev;

  assign resume_ev = wr_i &&  wen_i && wcont_i && (st_i == CH_HOLD);
  assign start_ev  = wr_i &&  wen_i && (st_i == CH_OFF);
  assign leave_ev  = wr_i && !wen_i && wcont_i && (st_i == CH_HOLD);

  always_comb begin
    st_o     = st_i;
    err_o    = err_i;
    en_o     = en_i;
    cont_o   = cont_i;
    reload_o = 1'b0;
    adv_o    = 1'b0;
    fetch_o  = 1'b0;
    if (wr_i) begin
      en_o   = wen_i;
      cont_o = wcont_i;
      if (wen_i) err_o = 1'b0;
    end
    if (resume_ev) begin
      reload_o = wstart_i;
      adv_o    = !wstart_i;
      fetch_o  = 1'b1;
      cont_o   = 1'b0;
      st_o     = CH_RUN;
    end else if (start_ev) begin
      reload_o = 1'b1;
      fetch_o  = 1'b1;
      st_o     = CH_RUN;
    end else if (leave_ev) begin
      st_o = CH_OFF;
    end
  end

endmodule

// File: rtl/dma_rc_pulse_reg.sv
module dma_rc_pulse_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q_o[g] <= 1'b0;
      else        q_o[g] <= d_i[g];
    end
  end

endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import dma_rc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_cont,
  input  logic             ctl_cont_start,
  input  logic             fetch_err,
  input  logic             dsc_done,
  input  logic [CMD_W-1:0] dsc_cmd,
  input  logic             dsc_reg_mode,
  output logic [STAT_W-1:0] chan_status,
  output logic             en_bit,
  output logic             cont_bit,
  output logic             ptr_reload,
  output logic             ptr_advance,
  output logic             fetch_req,
  output logic             done_pulse,
  output logic             pause_pulse
);

  ch_state_e st_q, mid_st, nxt_st;
  logic      err_q, en_q, cont_q;
  logic      mid_err, mid_en;
  logic      nxt_err, nxt_en, nxt_cont;
  logic      cpl_done, cpl_pause, cpl_adv, cpl_fetch;
  logic      wr_reload, wr_adv, wr_fetch;
  logic [PULSE_N-1:0] pulse_d, pulse_q;

  dma_rc_completion u_cpl (
    .st_i(st_q), .err_i(err_q), .en_i(en_q),
    .fetch_err_i(fetch_err), .dsc_done_i(dsc_done),
    .dsc_cmd_i(dsc_cmd), .reg_mode_i(dsc_reg_mode),
    .st_o(mid_st), .err_o(mid_err), .en_o(mid_en),
    .done_o(cpl_done), .pause_o(cpl_pause),
    .adv_o(cpl_adv), .fetch_o(cpl_fetch)
  );

  dma_rc_write_eval u_wr (
    .st_i(mid_st), .err_i(mid_err), .en_i(mid_en), .cont_i(cont_q),
    .wr_i(ctl_wr), .wen_i(ctl_en), .wcont_i(ctl_cont),
    .wstart_i(ctl_cont_start),
    .st_o(nxt_st), .err_o(nxt_err), .en_o(nxt_en), .cont_o(nxt_cont),
    .reload_o(wr_reload), .adv_o(wr_adv), .fetch_o(wr_fetch)
  );

  always_comb begin
    pulse_d            = '0;
    pulse_d[PI_RELOAD] = wr_reload;
    pulse_d[PI_ADV]    = cpl_adv | wr_adv;
    pulse_d[PI_FETCH]  = cpl_fetch | wr_fetch;
    pulse_d[PI_DONE]   = cpl_done;
    pulse_d[PI_PAUSE]  = cpl_pause;
  end

  dma_rc_pulse_reg #(.N(PULSE_N)) u_pulse (
    .clk(clk), .rst_n(rst_n), .d_i(pulse_d), .q_o(pulse_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CH_OFF;
      err_q  <= 1'b0;
      en_q   <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      st_q   <= nxt_st;
      err_q  <= nxt_err;
      en_q   <= nxt_en;
      cont_q <= nxt_cont;
    end
  end

  assign chan_status = status_code(st_q, err_q);
  assign en_bit      = en_q;
  assign cont_bit    = cont_q;
  assign ptr_reload  = pulse_q[PI_RELOAD];
  assign ptr_advance = pulse_q[PI_ADV];
  assign fetch_req   = pulse_q[PI_FETCH];
  assign done_pulse  = pulse_q[PI_DONE];
  assign pause_pulse = pulse_q[PI_PAUSE];

  assert_err_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN && fetch_err && !(ctl_wr && ctl_en)) |=> (chan_status == STAT_ERR));

  assert_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_HOLD && ctl_wr && ctl_en && ctl_cont)
      |=> (!cont_bit && chan_status == STAT_W'(1) && fetch_req));

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_en) |=> (chan_status != STAT_ERR));

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN && dsc_done && !fetch_err) |=> done_pulse);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN && dsc_done && !fetch_err && !ctl_wr &&
     (dsc_reg_mode || dsc_cmd == CMD_STOP))
      |=> (chan_status == STAT_W'(0) && !en_bit));

  assert_ptr_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_reload && ptr_advance));

  assert_fetch_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (ptr_reload || ptr_advance));

endmodule

// File: tb/dma_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_run_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_en, ctl_cont, ctl_cont_start, fetch_err, dsc_done, dsc_reg_mode;
  logic [1:0] dsc_cmd;
  logic [1:0] chan_status;
  logic en_bit, cont_bit, ptr_reload, ptr_advance, fetch_req, done_pulse, pause_pulse;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_run_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_cont(ctl_cont), .ctl_cont_start(ctl_cont_start),
    .fetch_err(fetch_err), .dsc_done(dsc_done), .dsc_cmd(dsc_cmd),
    .dsc_reg_mode(dsc_reg_mode), .chan_status(chan_status),
    .en_bit(en_bit), .cont_bit(cont_bit), .ptr_reload(ptr_reload),
    .ptr_advance(ptr_advance), .fetch_req(fetch_req),
    .done_pulse(done_pulse), .pause_pulse(pause_pulse)
  );

  // bench model: state 0 off, 1 run, 2 hold
  logic [1:0] m_st;
  logic m_err, m_en, m_cont;
  logic [4:0] m_pul; // {pause, done, fetch, adv, reload}

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [1:0] est;
    est = m_err ? 2'd3 : m_st;
    check(tag, {4'd0, chan_status, en_bit, cont_bit}, {4'd0, est, m_en, m_cont});
    check(tag, {3'd0, pause_pulse, done_pulse, fetch_req, ptr_advance, ptr_reload},
          {3'd0, m_pul});
    check("R12", {6'd0, ptr_reload & ptr_advance, fetch_req & ~(ptr_reload | ptr_advance)},
          8'd0);
  endtask

  task automatic cyc(logic wr, logic wen, logic wc, logic ws, logic dn,
                     logic [1:0] cmd, logic rm, logic fe);
    string tag;
    logic done_seen;
    @(negedge clk);
    ctl_wr = wr; ctl_en = wen; ctl_cont = wc; ctl_cont_start = ws;
    dsc_done = dn; dsc_cmd = cmd; dsc_reg_mode = rm; fetch_err = fe;
    tag = "R10";
    m_pul = '0;
    done_seen = 1'b0;
    if (m_st == 2'd1 && fe) begin
      m_err = 1'b1; m_st = 2'd0; tag = "R2";
    end else if (m_st == 2'd1 && dn) begin
      m_pul[3] = 1'b1; done_seen = 1'b1; tag = "R7";
      if (rm || cmd == 2'd2) begin
        m_en = 1'b0; m_st = 2'd0; tag = "R8";
      end else if (cmd == 2'd1) begin
        m_st = 2'd2; m_pul[4] = 1'b1; tag = "R9";
      end else begin
        m_pul[1] = 1'b1; m_pul[2] = 1'b1; tag = "R9";
      end
    end else if (fe) tag = "R2";
    if (wr) begin
      m_en = wen; m_cont = wc;
      if (wen && m_err) begin m_err = 1'b0; tag = "R6"; end
      if (wen && wc && m_st == 2'd2) begin
        m_pul[0] = ws; m_pul[1] = ~ws; m_pul[2] = 1'b1;
        m_cont = 1'b0; m_st = 2'd1; tag = "R4";
      end else if (wen && m_st == 2'd0) begin
        m_pul[0] = 1'b1; m_pul[2] = 1'b1; m_st = 2'd1; tag = "R3";
      end else if (!wen && wc && m_st == 2'd2) begin
        m_st = 2'd0; tag = "R5";
      end
      if (done_seen) tag = "R11";
    end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 2'd0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ctl_wr = 0; ctl_en = 0; ctl_cont = 0; ctl_cont_start = 0;
    fetch_err = 0; dsc_done = 0; dsc_cmd = 0; dsc_reg_mode = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_st = 2'd0; m_err = 0; m_en = 0; m_cont = 0; m_pul = '0;
    #1;
    check_all("R1");
  endtask

  task automatic setup(int s);
    if (s >= 1) cyc(1, 1, 0, 0, 0, 2'd0, 0, 0);          // start (R3)
    if (s == 2) cyc(0, 0, 0, 0, 1, 2'd1, 0, 0);          // halt (R9)
    if (s == 3) cyc(0, 0, 0, 0, 0, 2'd0, 0, 1);          // fetch error (R2)
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    // directed: start, normal completion, halt, resume from start
    cyc(1, 1, 0, 0, 0, 2'd0, 0, 0); // R3
    idle();
    cyc(0, 0, 0, 0, 1, 2'd0, 0, 0); // R9 advance
    cyc(0, 0, 0, 0, 1, 2'd1, 0, 0); // R9 halt
    cyc(1, 1, 1, 1, 0, 2'd0, 0, 0); // R4 reload
    cyc(0, 0, 0, 0, 1, 2'd1, 0, 0);
    cyc(1, 1, 1, 0, 0, 2'd0, 0, 0); // R4 advance
    cyc(1, 1, 0, 0, 0, 2'd0, 0, 0); // R10 no effect while running
    cyc(0, 0, 0, 0, 1, 2'd3, 1, 0); // R8 register mode
    // exhaustive sweep of one-cycle input combinations per reachable state
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 512; c++) begin
        logic [8:0] v;
        v = 9'(c);
        do_reset();
        setup(s);
        cyc(v[0], v[1], v[2], v[3], v[4], v[6:5], v[7], v[8]);
        idle();
        idle();
      end
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule